// File: doc/BRIEF.md
# Three-Byte Serial Converter Reader

This block is the host side of a single conversion on a serial 12-bit analog-to-digital converter. After a start request it pulls chip select low and runs three 8-bit SPI transfers in mode 0: clock idle low, data sampled on the rising edge and changed on the falling edge. The first byte out is a command byte. It carries a start bit, the channel number, the input polarity and single-ended/differential selections, and two trailing ones that ask the converter to use the external serial clock. The next two bytes out are zeros. They exist only to clock the conversion result back.

The byte returned during the command transfer is thrown away. Of the following sixteen returned bits, the block keeps the twelve that sit after one leading pad bit and before three trailing pad bits. It presents them as the result with a one-cycle done pulse.

The serial clock half-period is set in system clocks and forced into a legal window. A programmable idle gap may be placed between bytes. Because the sampled input droops if a conversion drags on, the whole frame is bounded by a fixed cycle budget. A frame that overruns it is cut short and reported as a timeout.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset and whenever idle, csN is 1, sclk is 0, busy is 0 and done is 0.
- R2: sclk is 0 whenever csN is 1, and csN changes only while sclk is 0. A complete frame has exactly 24 sclk rising edges.
- R3: The first 8 bits shifted out on mosi, MSB first, are bit7=1, bits6:4=channel, bit3=unipolar, bit2=singleEnded, bits1:0=2'b11. These inputs are captured when the start is accepted. The remaining 16 bits are 0.
- R4: On a normal done, result equals returned bits 14:3 of the 24-bit returned stream, counting bit 23 as the first one received. That is {second byte[6:0], third byte[7:3]}. The first returned byte and the pad bits have no effect on result.
- R5: Each sclk high phase and each ordinary low phase lasts H system clocks, where H is divSetting clamped to the range DIV_MIN..DIV_MAX (defaults 32..625). With a 125 MHz clock this keeps SCLK between about 100 kHz and 2 MHz.
- R6: The low phase after the 8th and after the 16th rising edge lasts H plus gapCycles system clocks.
- R7: A start is accepted only when busy is 0. busy stays 1 from acceptance until the cycle in which done is 1, and busy is 0 in that cycle. A start while busy has no effect on the frame and produces no extra done.
- R8: A normal frame takes 50*H + 2*gapCycles cycles, from the edge that accepts the start to the edge that raises done. If that would exceed MAX_FRAME_CYC (default 15000, i.e. 120 us at 125 MHz), the frame is aborted exactly MAX_FRAME_CYC cycles after acceptance. The abort drives csN to 1 and sclk to 0, raises done with timeoutErr=1, and leaves result unchanged.
- R9: done is a one-cycle pulse, and timeoutErr is 1 only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, taken when idle |
| channel | input | 3 | Converter channel number |
| unipolar | input | 1 | 1 = unipolar input range |
| singleEnded | input | 1 | 1 = single-ended input, 0 = differential |
| divSetting | input | DIV_W (10) | Requested SCLK half-period in system clocks |
| gapCycles | input | GAP_W (8) | Extra idle clocks between bytes |
| miso | input | 1 | Serial data from converter |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to converter |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| timeoutErr | output | 1 | Frame aborted on the cycle budget (with done) |
| result | output | 12 | Extracted conversion value |

## Verification
The converter model returns all-zero and all-one values. It alternates clean zero pads with pads and a discarded first byte that are all ones, which separates a correct bit window from one shifted by a position or one that leaks pad bits. Divider settings below, inside and above the legal window, each with a different gap, show whether clamping and gap insertion land exactly where expected, measured both per phase and as total frame length. One frame gets a second start mid-way with a different channel, to show that requests are ignored while busy. The slowest setting overruns the budget, which shows the abort timing and that the previous result is kept, and the frame after it shows recovery.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int CMD_BITS   = 8;
  localparam int BYTE_COUNT = 3;
  localparam int FRAME_BITS = CMD_BITS * BYTE_COUNT;
  localparam int RES_W      = 12;
  localparam int LEAD_PAD   = 1;
  localparam int RES_FIRST  = CMD_BITS + LEAD_PAD;
  localparam int RES_LAST   = RES_FIRST + RES_W - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_XFER, S_GAP, S_TRAIL
  } seqState_t;

  typedef struct packed {
    logic loadCmd;
    logic shiftOut;
    logic loadZero;
    logic captureBit;
    logic finish;
    logic clear;
  } dpStrobe_t;
endpackage

// File: rtl/adcrd_datapath.sv
module adcrd_datapath
  import adcrd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [2:0]       channel,
  input  logic             unipolar,
  input  logic             singleEnded,
  input  logic             miso,
  output logic             mosi,
  output logic [RES_W-1:0] result
);
  logic [CMD_BITS-1:0] txReg;
  logic [RES_W-1:0]    rxReg;
  logic [CMD_BITS-1:0] cmdByte;

  assign cmdByte = {1'b1, channel, unipolar, singleEnded, 2'b11};
  assign mosi    = txReg[CMD_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg  <= '0;
      rxReg  <= '0;
      result <= '0;
    end else begin
      if (strobe.loadCmd) begin
        txReg <= cmdByte;
        rxReg <= '0;
      end else if (strobe.loadZero || strobe.clear) begin
        txReg <= '0;
      end else if (strobe.shiftOut) begin
        txReg <= {txReg[CMD_BITS-2:0], 1'b0};
      end
      if (strobe.captureBit) rxReg <= {rxReg[RES_W-2:0], miso};
      if (strobe.finish) result <= rxReg;
    end
  end
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int DIV_W         = 10,
  parameter int DIV_MIN       = 32,
  parameter int DIV_MAX       = 625,
  parameter int GAP_W         = 8,
  parameter int MAX_FRAME_CYC = 15000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] divSetting,
  input  logic [GAP_W-1:0] gapCycles,
  output logic             csN,
  output logic             sclk,
  output logic             busy,
  output logic             done,
  output logic             timeoutErr,
  output dpStrobe_t        strobe
);
  localparam int TMR_W = $clog2(MAX_FRAME_CYC + 1);
  localparam int POS_W = $clog2(FRAME_BITS);

  seqState_t        state;
  logic [DIV_W-1:0] halfP, divCnt, divEff;
  logic [GAP_W-1:0] gapLim, gapCnt;
  logic [2:0]       bitCnt;
  logic [1:0]       byteIdx;
  logic [TMR_W-1:0] elapsed;
  logic [POS_W-1:0] framePos;
  logic tick, lastBit, lastByte, expired, finishNow, abortNow, fallNow;

  always_comb begin
    if (divSetting < DIV_W'(DIV_MIN))      divEff = DIV_W'(DIV_MIN);
    else if (divSetting > DIV_W'(DIV_MAX)) divEff = DIV_W'(DIV_MAX);
    else                                   divEff = divSetting;
  end

  assign tick      = (divCnt == halfP - 1'b1);
  assign lastBit   = (bitCnt == 3'd7);
  assign lastByte  = (byteIdx == 2'(BYTE_COUNT - 1));
  assign framePos  = POS_W'({byteIdx, bitCnt});
  assign expired   = (elapsed == TMR_W'(MAX_FRAME_CYC - 1));
  assign finishNow = (state == S_TRAIL) && tick;
  assign abortNow  = (state != S_IDLE) && expired && !finishNow;
  assign fallNow   = (state == S_XFER) && tick && sclk;
  assign busy      = (state != S_IDLE);

  always_comb begin
    strobe            = '0;
    strobe.loadCmd    = (state == S_IDLE) && start;
    strobe.captureBit = (state == S_XFER) && tick && !sclk &&
                        (framePos >= POS_W'(RES_FIRST)) &&
                        (framePos <= POS_W'(RES_LAST));
    strobe.shiftOut   = fallNow && !lastBit;
    strobe.loadZero   = fallNow && lastBit;
    strobe.finish     = finishNow;
    strobe.clear      = abortNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) elapsed <= '0;
    else if (state == S_IDLE) elapsed <= '0;
    else elapsed <= elapsed + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      csN        <= 1'b1;
      sclk       <= 1'b0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
      halfP      <= DIV_W'(DIV_MIN);
      divCnt     <= '0;
      gapLim     <= '0;
      gapCnt     <= '0;
      bitCnt     <= '0;
      byteIdx    <= '0;
    end else begin
      done       <= 1'b0;
      timeoutErr <= 1'b0;
      if (abortNow) begin
        state      <= S_IDLE;
        csN        <= 1'b1;
        sclk       <= 1'b0;
        done       <= 1'b1;
        timeoutErr <= 1'b1;
      end else begin
        unique case (state)
          S_IDLE: if (start) begin
            halfP   <= divEff;
            gapLim  <= gapCycles;
            csN     <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= '0;
            byteIdx <= '0;
            state   <= S_LEAD;
          end
          S_LEAD: begin
            divCnt <= tick ? '0 : divCnt + 1'b1;
            if (tick) state <= S_XFER;
          end
          S_XFER: begin
            divCnt <= tick ? '0 : divCnt + 1'b1;
            if (tick) begin
              if (!sclk) sclk <= 1'b1;
              else begin
                sclk   <= 1'b0;
                bitCnt <= bitCnt + 1'b1;
                if (lastBit) begin
                  if (lastByte) state <= S_TRAIL;
                  else begin
                    byteIdx <= byteIdx + 1'b1;
                    gapCnt  <= '0;
                    if (gapLim != '0) state <= S_GAP;
                  end
                end
              end
            end
          end
          S_GAP: begin
            gapCnt <= gapCnt + 1'b1;
            if (gapCnt == gapLim - 1'b1) begin
              divCnt <= '0;
              state  <= S_XFER;
            end
          end
          S_TRAIL: begin
            divCnt <= tick ? '0 : divCnt + 1'b1;
            if (tick) begin
              csN   <= 1'b1;
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adcrd_pkg::*;
#(
  parameter int DIV_W         = 10,
  parameter int DIV_MIN       = 32,
  parameter int DIV_MAX       = 625,
  parameter int GAP_W         = 8,
  parameter int MAX_FRAME_CYC = 15000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [2:0]       channel,
  input  logic             unipolar,
  input  logic             singleEnded,
  input  logic [DIV_W-1:0] divSetting,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic             miso,
  output logic             csN,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic             timeoutErr,
  output logic [11:0]      result
);
  dpStrobe_t strobe;

  adcrd_ctrl #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
    .GAP_W(GAP_W), .MAX_FRAME_CYC(MAX_FRAME_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .divSetting(divSetting),
    .gapCycles(gapCycles), .csN(csN), .sclk(sclk), .busy(busy),
    .done(done), .timeoutErr(timeoutErr), .strobe(strobe)
  );

  adcrd_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .channel(channel),
    .unipolar(unipolar), .singleEnded(singleEnded), .miso(miso),
    .mosi(mosi), .result(result)
  );
endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker #(
  parameter int MAX_FRAME_CYC = 15000
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic busy,
  input logic done,
  input logic timeoutErr
);
  int unsigned winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winCnt <= 0;
    else if (!busy) winCnt <= 0;
    else winCnt <= winCnt + 1;
  end

  a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);
  a_r2_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  a_r2_select_with_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);
  a_r7_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r8_frame_budget: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (winCnt < MAX_FRAME_CYC));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> done);
endmodule

bind adc_frame_reader adcrd_checker #(.MAX_FRAME_CYC(MAX_FRAME_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .busy(busy),
  .done(done), .timeoutErr(timeoutErr)
);

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;
  localparam int MAXC = 15000;

  logic clk = 0, rstN = 0, start = 0, unipolar = 0, singleEnded = 0, miso = 0;
  logic [2:0] channel = 0;
  logic [9:0] divSetting = 10'd32;
  logic [7:0] gapCycles = 0;
  logic csN, sclk, mosi, busy, done, timeoutErr;
  logic [11:0] result;

  always #4 clk = ~clk;

  adc_frame_reader dut (
    .clk(clk), .rstN(rstN), .start(start), .channel(channel),
    .unipolar(unipolar), .singleEnded(singleEnded), .divSetting(divSetting),
    .gapCycles(gapCycles), .miso(miso), .csN(csN), .sclk(sclk), .mosi(mosi),
    .busy(busy), .done(done), .timeoutErr(timeoutErr), .result(result)
  );

  typedef struct {
    logic [7:0]  cmd;
    logic [11:0] res;
    bit          err;
    int          half;
    int          gap;
    int          dur;
  } exp_t;

  exp_t expQ[$];
  int hiQ[$];
  int lowQ[$];
  int nChecks = 0, nFails = 0, doneCnt = 0, cycCnt = 0, startCyc = 0;
  logic [23:0] resp = '0;
  logic [23:0] mosiCap = '0;
  int sIdx = 0, riseCnt = 0, hiRun = 0, lowRun = 0;
  bit seenRise = 0, finished = 0;
  logic [11:0] lastRes = '0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) cycCnt <= cycCnt + 1;

  // converter model
  always @(negedge csN) begin
    sIdx = 23; miso = resp[23]; riseCnt = 0; mosiCap = '0;
  end
  always @(negedge sclk) if (csN === 1'b0 && sIdx > 0) begin
    sIdx--; miso = resp[sIdx];
  end
  always @(posedge sclk) begin
    mosiCap = {mosiCap[22:0], mosi}; riseCnt++;
  end

  // phase length probe
  always @(negedge clk) if (rstN) begin
    if (csN) begin hiRun = 0; lowRun = 0; seenRise = 0; end
    else if (sclk) begin
      if (seenRise && lowRun > 0) lowQ.push_back(lowRun);
      lowRun = 0; hiRun++; seenRise = 1;
    end else begin
      if (hiRun > 0) hiQ.push_back(hiRun);
      hiRun = 0; lowRun++;
    end
  end

  // monitor
  always @(negedge clk) if (rstN && done) begin
    exp_t e;
    bit okHi, okLow;
    int dur;
    dur = cycCnt - startCyc;
    check(expQ.size() > 0, "R9", "done without request", 1, 0);
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      check(timeoutErr == e.err, "R8", "timeoutErr", timeoutErr, e.err);
      check(result == e.res, e.err ? "R8" : "R4", "result", result, e.res);
      check(dur == e.dur, e.err ? "R8" : "R5", "frame length", dur, e.dur);
      check(csN == 1'b1 && sclk == 1'b0, "R8", "lines released", {csN, sclk}, 2);
      okHi = hiQ.size() > 0;
      foreach (hiQ[i]) if (hiQ[i] != e.half) okHi = 0;
      check(okHi, "R5", "high phase length", hiQ.size() > 0 ? hiQ[0] : -1, e.half);
      okLow = 1;
      foreach (lowQ[i]) if (lowQ[i] != ((i == 7 || i == 15) ? e.half + e.gap : e.half)) okLow = 0;
      check(okLow, "R6", "low phase lengths", lowQ.size() > 7 ? lowQ[7] : -1, e.half + e.gap);
      if (!e.err) begin
        check(riseCnt == 24 && lowQ.size() == 23, "R2", "rising edges", riseCnt, 24);
        check(mosiCap[23:16] == e.cmd, "R3", "command byte", mosiCap[23:16], e.cmd);
        check(mosiCap[15:0] == 16'h0, "R3", "zero bytes", mosiCap[15:0], 0);
      end
    end
    doneCnt++;
  end

  task automatic runFrame(input logic [2:0] ch, input bit uni, input bit sgl,
                          input int div, input int gap, input logic [11:0] val,
                          input bit junk, input bit poke);
    exp_t e;
    int h;
    int target;
    h = (div < 32) ? 32 : ((div > 625) ? 625 : div);
    e.cmd  = {1'b1, ch, uni, sgl, 2'b11};
    e.half = h;
    e.gap  = gap;
    e.err  = (50 * h + 2 * gap) > MAXC;
    e.dur  = e.err ? MAXC : 50 * h + 2 * gap;
    e.res  = e.err ? lastRes : val;
    if (!e.err) lastRes = val;
    resp = junk ? {8'hFF, 1'b1, val, 3'b111} : {8'h00, 1'b0, val, 3'b000};
    hiQ.delete(); lowQ.delete();
    expQ.push_back(e);
    target = doneCnt + 1;
    @(negedge clk);
    channel = ch; unipolar = uni; singleEnded = sgl;
    divSetting = 10'(div); gapCycles = 8'(gap); start = 1;
    startCyc = cycCnt + 1;
    @(negedge clk);
    start = 0; channel = ~ch; unipolar = ~uni; singleEnded = ~sgl;
    if (poke) begin
      repeat (300) @(negedge clk);
      channel = 3'd1; start = 1;
      @(negedge clk);
      start = 0;
      check(busy == 1'b1, "R7", "busy after ignored start", busy, 1);
    end
    wait (doneCnt == target);
    repeat (40) @(negedge clk);
    check(doneCnt == target, "R7", "done count", doneCnt, target);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(csN == 1 && sclk == 0 && busy == 0 && done == 0, "R1", "reset outputs",
          {csN, sclk, busy, done}, 8);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(csN == 1 && sclk == 0 && busy == 0, "R1", "idle outputs", {csN, sclk, busy}, 4);
    runFrame(3'd0, 1, 1, 32, 0, 12'h000, 0, 0);
    runFrame(3'd5, 0, 1, 40, 25, 12'hFFF, 1, 0);
    runFrame(3'd7, 1, 0, 1, 3, 12'hA5C, 1, 1);    // lower clamp, ignored start
    runFrame(3'd2, 0, 0, 1000, 0, 12'h123, 0, 0); // upper clamp, overruns budget
    runFrame(3'd6, 1, 1, 33, 255, 12'h5A3, 0, 0); // recovery, long gap
    check(expQ.size() == 0, "R9", "pending expectations", expQ.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule